// File: doc/BRIEF.md
# Masked Interrupt Aggregator

This block gathers eight level-sensitive event conditions from a two-channel serial controller (per-channel transmitter ready, receiver ready, break change, plus a shared counter/timer event and an input-port change event) and folds them into one active-low interrupt request for the processor. A writable enable mask chooses which conditions may pull the request low. A status vector shows every live condition, whether it is enabled or not. Status bits are plain levels. A bit drops only when the event logic withdraws its condition after being serviced.

Five of the eight bits of the output port can also act as dedicated active-low interrupt pins, one per source. A per-pin configuration register picks this use. When a pin is not configured this way, it carries the value of a general-purpose output register instead. The event logic itself lies outside this block and shows up here only as level inputs.

Status bit order: bit 0 transmitter A ready, bit 1 receiver A ready, bit 2 break A, bit 3 counter/timer, bit 4 transmitter B ready, bit 5 receiver B ready, bit 6 break B, bit 7 input-port change.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the mask, the pin configuration and the general-purpose output register are all zero, the status reads zero, irqN is high and portOut is zero.
- R2: statusOut equals the srcLevel vector captured at the previous rising clock edge, whatever the mask holds.
- R3: A mask write (maskWrEn high) loads maskWrData at that clock edge. maskOut shows the new value from the next cycle on.
- R4: irqN is low exactly when some status bit and the matching mask bit are both 1.
- R5: When every enabled source falls back to 0, irqN returns high one cycle later. No clearing action is needed.
- R6: When configuration bit j (0 to 4) is 1, portOut[3+j] is the inverted status of its source. The sources are: port bit 3 takes status bit 3, port bit 4 takes bit 1, port bit 5 takes bit 5, port bit 6 takes bit 0, and port bit 7 takes bit 4. These pins ignore the mask.
- R7: When configuration bit j is 0, portOut[3+j] equals general-purpose output bit 3+j.
- R8: portOut[2:0] always equals general-purpose output bits 2:0, and no source affects them.
- R9: A source whose mask bit is 0 appears in statusOut but leaves irqN high.
- R10: Mask, configuration and general-purpose output writes issued in the same cycle all take effect together at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| srcLevel | input | 8 | Raw event condition levels |
| maskWrEn | input | 1 | Load the interrupt mask |
| maskWrData | input | 8 | New mask value |
| cfgWrEn | input | 1 | Load the discrete pin configuration |
| cfgWrData | input | 5 | Per-pin enable for port bits 3 to 7 |
| gpoWrEn | input | 1 | Load the general-purpose output register |
| gpoWrData | input | 8 | New general-purpose output value |
| statusOut | output | 8 | Registered raw status |
| maskOut | output | 8 | Current mask |
| irqN | output | 1 | Combined interrupt request, active low |
| portOut | output | 8 | Output port pins |

## Verification
Every result is due one clock after its cause. A source change shows up in statusOut, irqN and the discrete pins after the edge that captures it. A write shows up in maskOut, irqN or portOut after the edge that loads it. No output needs a second cycle. The bench drives inputs on the falling edge and queues the expected outputs for the next rising edge. A monitor pops one entry 2 ns after each rising edge and compares it, so every check lands exactly one register stage after its stimulus.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int NUM_SRC = 8;
  localparam int PORT_W  = 8;
  localparam int DISC_LO = 3;
  localparam int DISC_N  = 5;

  typedef struct packed {
    logic loadMask;
    logic loadCfg;
    logic loadGpo;
  } strobes_t;

  // status bit that drives a given discrete port pin
  function automatic int discSrc(input int portBit);
    case (portBit)
      3:       return 3;
      4:       return 1;
      5:       return 5;
      6:       return 0;
      7:       return 4;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     maskWrEn,
  input  logic     cfgWrEn,
  input  logic     gpoWrEn,
  output strobes_t strb
);
  always_comb begin
    strb.loadMask = maskWrEn;
    strb.loadCfg  = cfgWrEn;
    strb.loadGpo  = gpoWrEn;
  end

  // R10: independent strobes, so concurrent writes all reach the datapath
  assert_strobes_concurrent_R10: assert property (@(posedge clk) disable iff (!rstN)
    (maskWrEn && cfgWrEn && gpoWrEn) |-> (strb.loadMask && strb.loadCfg && strb.loadGpo));
endmodule

// File: rtl/irq_agg_datapath.sv
module irq_agg_datapath
  import irq_agg_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  strobes_t            strb,
  input  logic [NUM_SRC-1:0]  srcLevel,
  input  logic [NUM_SRC-1:0]  maskWrData,
  input  logic [DISC_N-1:0]   cfgWrData,
  input  logic [PORT_W-1:0]   gpoWrData,
  output logic [NUM_SRC-1:0]  statusOut,
  output logic [NUM_SRC-1:0]  maskOut,
  output logic                irqN,
  output logic [PORT_W-1:0]   portOut
);
  logic [NUM_SRC-1:0] statusQ;
  logic [NUM_SRC-1:0] maskQ;
  logic [DISC_N-1:0]  cfgQ;
  logic [PORT_W-1:0]  gpoQ;
  logic               validQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      maskQ   <= '0;
      cfgQ    <= '0;
      gpoQ    <= '0;
      validQ  <= 1'b0;
    end else begin
      statusQ <= srcLevel;
      validQ  <= 1'b1;
      if (strb.loadMask) maskQ <= maskWrData;
      if (strb.loadCfg)  cfgQ  <= cfgWrData;
      if (strb.loadGpo)  gpoQ  <= gpoWrData;
    end
  end

  assign statusOut = statusQ;
  assign maskOut   = maskQ;
  assign irqN      = ~|(statusQ & maskQ);

  for (genvar b = 0; b < PORT_W; b++) begin : g_port
    if (b >= DISC_LO && b < DISC_LO + DISC_N) begin : g_disc
      localparam int SRC = discSrc(b);
      assign portOut[b] = cfgQ[b-DISC_LO] ? ~statusQ[SRC] : gpoQ[b];
    end else begin : g_plain
      assign portOut[b] = gpoQ[b];
    end
  end

  assert_status_tracks_R2: assert property (@(posedge clk) disable iff (!rstN)
    validQ |-> (statusQ == $past(srcLevel)));

  assert_mask_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    (validQ && $past(strb.loadMask)) |-> (maskOut == $past(maskWrData)));

  assert_mask_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (validQ && !$past(strb.loadMask)) |-> $stable(maskOut));

  assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ == '0) |-> irqN);

  assert_disc_pin_R6: assert property (@(posedge clk) disable iff (!rstN)
    (validQ && cfgQ[0]) |-> (portOut[DISC_LO] == ~$past(srcLevel[discSrc(DISC_LO)])));

  assert_gpo_load_R10: assert property (@(posedge clk) disable iff (!rstN)
    (validQ && $past(strb.loadGpo)) |-> (portOut[DISC_LO-1:0] == $past(gpoWrData[DISC_LO-1:0])));
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_SRC-1:0]  srcLevel,
  input  logic                maskWrEn,
  input  logic [NUM_SRC-1:0]  maskWrData,
  input  logic                cfgWrEn,
  input  logic [DISC_N-1:0]   cfgWrData,
  input  logic                gpoWrEn,
  input  logic [PORT_W-1:0]   gpoWrData,
  output logic [NUM_SRC-1:0]  statusOut,
  output logic [NUM_SRC-1:0]  maskOut,
  output logic                irqN,
  output logic [PORT_W-1:0]   portOut
);
  strobes_t strb;

  irq_agg_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .maskWrEn (maskWrEn),
    .cfgWrEn  (cfgWrEn),
    .gpoWrEn  (gpoWrEn),
    .strb     (strb)
  );

  irq_agg_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .srcLevel   (srcLevel),
    .maskWrData (maskWrData),
    .cfgWrData  (cfgWrData),
    .gpoWrData  (gpoWrData),
    .statusOut  (statusOut),
    .maskOut    (maskOut),
    .irqN       (irqN),
    .portOut    (portOut)
  );
endmodule

// File: tb/sim_irq_aggregator.sv
`timescale 1ns/1ps
module sim_irq_aggregator;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] srcLevel = '0;
  logic       maskWrEn = 1'b0;
  logic [7:0] maskWrData = '0;
  logic       cfgWrEn = 1'b0;
  logic [4:0] cfgWrData = '0;
  logic       gpoWrEn = 1'b0;
  logic [7:0] gpoWrData = '0;
  logic [7:0] statusOut, maskOut, portOut;
  logic       irqN;

  always #5 clk = ~clk;

  irq_aggregator u0 (
    .clk(clk), .rstN(rstN), .srcLevel(srcLevel),
    .maskWrEn(maskWrEn), .maskWrData(maskWrData),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .gpoWrEn(gpoWrEn), .gpoWrData(gpoWrData),
    .statusOut(statusOut), .maskOut(maskOut), .irqN(irqN), .portOut(portOut)
  );

  typedef struct {
    string      tag;
    logic [7:0] status;
    logic [7:0] mask;
    logic       irq;
    logic [7:0] port;
  } item_t;

  item_t expQ[$];
  int    checks = 0;
  int    errors = 0;
  bit    driving = 1'b0;
  bit    done = 1'b0;

  logic [7:0] mStatus = '0, mMask = '0, mGpo = '0;
  logic [4:0] mCfg = '0;

  function automatic int pinSrc(input int pb);
    if (pb == 3) return 3;
    if (pb == 4) return 1;
    if (pb == 5) return 5;
    if (pb == 6) return 0;
    return 4;
  endfunction

  function automatic logic [7:0] portModel();
    logic [7:0] p;
    p = mGpo;
    for (int k = 3; k < 8; k++)
      if (mCfg[k-3]) p[k] = ~mStatus[pinSrc(k)];
    return p;
  endfunction

  task automatic step(input string tag, input logic [7:0] src,
                      input logic mE, input logic [7:0] m,
                      input logic cE, input logic [4:0] c,
                      input logic gE, input logic [7:0] g);
    item_t it;
    @(negedge clk);
    srcLevel = src; maskWrEn = mE; maskWrData = m;
    cfgWrEn = cE; cfgWrData = c; gpoWrEn = gE; gpoWrData = g;
    mStatus = src;
    if (mE) mMask = m;
    if (cE) mCfg = c;
    if (gE) mGpo = g;
    it.tag = tag; it.status = mStatus; it.mask = mMask;
    it.irq = ((mStatus & mMask) == 8'h00); it.port = portModel();
    expQ.push_back(it);
  endtask

  // monitor: one comparison per cycle, 2 ns after the capturing edge
  always @(posedge clk) begin
    #2;
    if (expQ.size() > 0) begin
      item_t e;
      e = expQ.pop_front();
      checks++;
      if (statusOut !== e.status || maskOut !== e.mask || irqN !== e.irq || portOut !== e.port) begin
        errors++;
        $display("FAIL %s: got status=%h mask=%h irqN=%b port=%h, expected status=%h mask=%h irqN=%b port=%h",
                 e.tag, statusOut, maskOut, irqN, portOut, e.status, e.mask, e.irq, e.port);
      end
    end
  end

  initial begin
    #20000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (statusOut !== 8'h00 || maskOut !== 8'h00 || irqN !== 1'b1 || portOut !== 8'h00) begin
      errors++;
      $display("FAIL R1 in reset: got status=%h mask=%h irqN=%b port=%h, expected 00 00 1 00",
               statusOut, maskOut, irqN, portOut);
    end
    @(negedge clk); rstN = 1'b1;
    // R1: first cycle after reset, all quiet
    step("R1", 8'h00, 0, 8'h00, 0, 5'h00, 0, 8'h00);
    // R2/R9: sources live, mask zero, irq stays high
    step("R2", 8'hA5, 0, 8'h00, 0, 5'h00, 0, 8'h00);
    step("R9", 8'hFF, 0, 8'h00, 0, 5'h00, 0, 8'h00);
    // R3/R4: enable counter/timer only
    step("R3", 8'h08, 1, 8'h08, 0, 5'h00, 0, 8'h00);
    step("R4", 8'h08, 0, 8'h00, 0, 5'h00, 0, 8'h00);
    // R5: source withdrawn, request releases
    step("R5", 8'h00, 0, 8'h00, 0, 5'h00, 0, 8'h00);
    // R9: unmasked bit off, masked bits on
    step("R9", 8'hF7, 0, 8'h00, 0, 5'h00, 0, 8'h00);
    // R4: change mask to rx B, source present
    step("R4", 8'h20, 1, 8'h20, 0, 5'h00, 0, 8'h00);
    step("R4", 8'h80, 1, 8'hC0, 0, 5'h00, 0, 8'h00);
    // R7/R8: general-purpose output only
    step("R7", 8'h00, 0, 8'h00, 0, 5'h00, 1, 8'hB6);
    step("R8", 8'hFF, 0, 8'h00, 0, 5'h00, 0, 8'h00);
    // R6: each discrete pin individually
    step("R6", 8'h08, 0, 8'h00, 1, 5'h01, 0, 8'h00);
    step("R6", 8'h02, 0, 8'h00, 1, 5'h02, 0, 8'h00);
    step("R6", 8'h20, 0, 8'h00, 1, 5'h04, 0, 8'h00);
    step("R6", 8'h01, 0, 8'h00, 1, 5'h08, 0, 8'h00);
    step("R6", 8'h10, 0, 8'h00, 1, 5'h10, 0, 8'h00);
    step("R6", 8'h3B, 0, 8'h00, 1, 5'h1F, 0, 8'h00);
    step("R6", 8'h00, 0, 8'h00, 0, 5'h00, 0, 8'h00);
    // R7: partial config, rest from gpo
    step("R7", 8'h3B, 0, 8'h00, 1, 5'h0A, 1, 8'h5A);
    // R10: all three writes at once
    step("R10", 8'h11, 1, 8'h01, 1, 5'h15, 1, 8'hE3);
    step("R10", 8'h10, 0, 8'h00, 0, 5'h00, 0, 8'h00);
    step("R5", 8'h00, 0, 8'h00, 0, 5'h00, 0, 8'h00);
    step("R2", 8'h5A, 1, 8'hFF, 0, 5'h00, 0, 8'h00);
    step("R5", 8'h00, 0, 8'h00, 0, 5'h00, 0, 8'h00);
    @(negedge clk);
    maskWrEn = 0; cfgWrEn = 0; gpoWrEn = 0;
    while (expQ.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule